// File: doc/BRIEF.md
# Programmable Floating-Point Comparator

This block compares two floating-point operands of one shared, parameterised format. The format is set by a total width and a fraction width that counts the hidden bit. The exponent takes the bits in between, and the sign is the top bit. A 6-bit operation code, presented with a valid strobe, picks the comparison at run time. The code selects either one of seven predicates, which gives a single true/false bit, or a condition-code mode, which reports the relation as a 4-bit one-hot code.

Before the relation is formed, the operands are classified. A NaN has an all-ones exponent and a non-zero fraction. An infinity has an all-ones exponent and a zero fraction. An operand with a zero exponent is a zero or a denormal, and both are taken as zero with their own sign. The pipeline depth is a parameter from 0 to 3. At depth 0 the block is purely combinational. A ready strobe marks the cycle in which the result and the invalid flag are valid. A clock enable freezes all pipeline state, and a synchronous clear drops every operation in flight.

Top module: `fp_cmp_pipe`

## Requirements
- R1: The operation codes are: 0 unordered, 1 less, 2 equal, 3 less-or-equal, 4 greater, 5 not-equal, 6 greater-or-equal. For codes 0 to 6 the answer is in result bit 0, and bits 3:1 are 0.
- R2: Code 7 selects condition-code mode. Exactly one result bit is set: bit 3 unordered, bit 2 greater, bit 1 less, bit 0 equal.
- R3: An operand with an all-ones exponent and a non-zero fraction is a NaN. The pair is then unordered. Less, equal, less-or-equal, greater and greater-or-equal return 0. Unordered and not-equal return 1.
- R4: An operand with a zero exponent is compared as zero. The values +0, -0 and denormals of either sign are all equal to one another.
- R5: Ordered operands compare by sign and magnitude. A negative value is below a positive one. Of two negatives, the larger magnitude is the lesser value. Infinity lies beyond every finite value of the same sign.
- R6: The invalid flag is 1 when a NaN meets less, less-or-equal, greater or greater-or-equal. It is 0 for unordered, equal, not-equal and condition-code mode.
- R7: Codes 8 to 63 give result 0 and invalid 1.
- R8: With clock enable held high, res_valid and the matching result appear LATENCY cycles after op_valid. With LATENCY 0 they follow the inputs in the same cycle.
- R9: While ce is low, all pipeline state holds. An operation in flight is delayed by the cycles ce spent low and is not lost, and a valid output stays valid.
- R10: srst clears every pipeline valid bit. After srst, res_valid is 0, and no operation accepted before srst produces res_valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| srst | input | 1 | Synchronous clear, active high |
| ce | input | 1 | Clock enable; low freezes the pipeline |
| op_valid | input | 1 | Strobe qualifying op, a and b |
| op | input | 6 | Operation code |
| a | input | FMT_W | First operand |
| b | input | FMT_W | Second operand |
| res_valid | output | 1 | Result and invalid flag are valid |
| result | output | 4 | Predicate in bit 0, or condition code |
| invalid | output | 1 | Invalid-operation flag |

## Verification
The bench builds two instances. The first uses a 32-bit format with a 24-bit fraction and LATENCY 3. It puts every register cut in place, so the bench can check cycle-exact arrival, freezing in the middle of the pipe and clearing of operations in flight. The second uses a 16-bit format with an 11-bit fraction and LATENCY 0. It covers the purely combinational variant and a different exponent width, where the classification of NaN, infinity and denormal must still follow the field boundaries.

// File: rtl/fp_cmp_pkg.sv
`timescale 1ns/1ps
package fp_cmp_pkg;

  localparam int OP_W = 6;
  localparam int CC_W = 4;

  // Condition-code bit positions (decoded by consumers of the result)
  localparam int CC_EQ = 0;
  localparam int CC_LT = 1;
  localparam int CC_GT = 2;
  localparam int CC_UN = 3;

  typedef enum logic [OP_W-1:0] {
    CMP_UNORD = 6'd0,
    CMP_LT    = 6'd1,
    CMP_EQ    = 6'd2,
    CMP_LE    = 6'd3,
    CMP_GT    = 6'd4,
    CMP_NE    = 6'd5,
    CMP_GE    = 6'd6,
    CMP_CCODE = 6'd7
  } cmp_op_e;

  typedef struct packed {
    logic nan;
    logic inf;
    logic zero;   // zero exponent: true zero or denormal
    logic sign;
  } fp_class_t;

  localparam int CLS_W = $bits(fp_class_t);

endpackage

// File: rtl/fp_cmp_stage.sv
`timescale 1ns/1ps
// One optional register cut with a valid bit. EN=0 makes it a wire.
module fp_cmp_stage #(
  parameter int W  = 8,
  parameter bit EN = 1'b1
) (
  input  logic         clk,
  input  logic         srst,
  input  logic         ce,
  input  logic         vld_i,
  input  logic [W-1:0] d_i,
  output logic         vld_o,
  output logic [W-1:0] d_o
);

  generate
    if (EN) begin : g_reg
      logic         vld_q;
      logic [W-1:0] d_q;

      always_ff @(posedge clk) begin
        if (srst)    vld_q <= 1'b0;
        else if (ce) vld_q <= vld_i;
      end

      always_ff @(posedge clk) begin
        if (ce) d_q <= d_i;
      end

      assign vld_o = vld_q;
      assign d_o   = d_q;

      // R10: clear empties the valid bit on the next edge
      p_clear_empties_r10: assert property (@(posedge clk)
        srst |=> !vld_o);

      // R9: enable low freezes valid and data
      p_ce_freeze_r9: assert property (@(posedge clk) disable iff (srst)
        !ce |=> ($stable(vld_o) && $stable(d_o)));
    end else begin : g_wire
      logic unused_ctl;
      assign unused_ctl = ^{clk, srst, ce};
      assign vld_o = vld_i;
      assign d_o   = d_i;
    end
  endgenerate

endmodule

// File: rtl/fp_cmp_classify.sv
`timescale 1ns/1ps
// Splits one operand into class flags and an ordered magnitude key.
module fp_cmp_classify
  import fp_cmp_pkg::*;
#(
  parameter int FMT_W  = 32,
  parameter int FRAC_W = 24
) (
  input  logic [FMT_W-1:0] word_i,
  output fp_class_t        cls_o,
  output logic [FMT_W-2:0] mag_o
);

  localparam int EXP_W  = FMT_W - FRAC_W;
  localparam int STOR_W = FRAC_W - 1;      // stored fraction bits
  localparam int EXP_HI = FMT_W - 2;

  logic [EXP_W-1:0]  exp_f;
  logic [STOR_W-1:0] frac_f;
  logic exp_ones, exp_none, frac_any;

  assign exp_f    = word_i[EXP_HI -: EXP_W];
  assign frac_f   = word_i[STOR_W-1:0];
  assign exp_ones = &exp_f;
  assign exp_none = ~|exp_f;
  assign frac_any = |frac_f;

  always_comb begin
    cls_o.sign = word_i[FMT_W-1];
    cls_o.nan  = exp_ones & frac_any;
    cls_o.inf  = exp_ones & ~frac_any;
    cls_o.zero = exp_none;                 // denormals flushed to zero
    mag_o      = exp_none ? '0 : word_i[FMT_W-2:0];
  end

endmodule

// File: rtl/fp_cmp_order.sv
`timescale 1ns/1ps
// Forms the one-hot relation {un, gt, lt, eq} of two classified operands.
module fp_cmp_order
  import fp_cmp_pkg::*;
#(
  parameter int MAG_W = 31
) (
  input  fp_class_t        ca_i,
  input  fp_class_t        cb_i,
  input  logic [MAG_W-1:0] ma_i,
  input  logic [MAG_W-1:0] mb_i,
  output logic [CC_W-1:0]  rel_o
);

  logic sa, sb, m_lt, m_eq, m_gt;

  // A zero carries no effective sign, so +0 == -0
  assign sa   = ca_i.sign & ~ca_i.zero;
  assign sb   = cb_i.sign & ~cb_i.zero;
  assign m_lt = ma_i < mb_i;
  assign m_eq = ma_i == mb_i;
  assign m_gt = ~m_lt & ~m_eq;

  always_comb begin
    rel_o = '0;
    if (ca_i.nan | cb_i.nan) begin
      rel_o[CC_UN] = 1'b1;
    end else if (sa != sb) begin
      rel_o[CC_LT] = sa;
      rel_o[CC_GT] = sb;
    end else if (m_eq) begin
      rel_o[CC_EQ] = 1'b1;
    end else if (!sa) begin
      rel_o[CC_LT] = m_lt;
      rel_o[CC_GT] = m_gt;
    end else begin
      rel_o[CC_LT] = m_gt;                 // larger negative magnitude is lesser
      rel_o[CC_GT] = m_lt;
    end
  end

endmodule

// File: rtl/fp_cmp_select.sv
`timescale 1ns/1ps
// Maps a relation and an operation code to the result and invalid flag.
module fp_cmp_select
  import fp_cmp_pkg::*;
(
  input  logic            clk,
  input  logic            srst,
  input  logic            vld_i,
  input  logic [OP_W-1:0] op_i,
  input  logic [CC_W-1:0] rel_i,
  output logic [CC_W-1:0] res_o,
  output logic            inv_o
);

  logic un, gt, lt, eq, ordered_op;

  assign un = rel_i[CC_UN];
  assign gt = rel_i[CC_GT];
  assign lt = rel_i[CC_LT];
  assign eq = rel_i[CC_EQ];

  always_comb begin
    res_o      = '0;
    ordered_op = 1'b0;
    inv_o      = 1'b0;
    case (op_i)
      CMP_UNORD: res_o[0] = un;
      CMP_LT:    begin res_o[0] = lt;      ordered_op = 1'b1; end
      CMP_EQ:    res_o[0] = eq;
      CMP_LE:    begin res_o[0] = lt | eq; ordered_op = 1'b1; end
      CMP_GT:    begin res_o[0] = gt;      ordered_op = 1'b1; end
      CMP_NE:    res_o[0] = ~eq;
      CMP_GE:    begin res_o[0] = gt | eq; ordered_op = 1'b1; end
      CMP_CCODE: res_o = rel_i;
      default:   inv_o = 1'b1;
    endcase
    if (ordered_op && un) inv_o = 1'b1;
  end

  // R2: condition code is one-hot
  p_cc_onehot_r2: assert property (@(posedge clk) disable iff (srst)
    (vld_i && op_i == CMP_CCODE) |-> $onehot(res_o));

  // R1: predicates occupy bit 0 only
  p_pred_narrow_r1: assert property (@(posedge clk) disable iff (srst)
    (vld_i && op_i < CMP_CCODE) |-> (res_o[3:1] == 3'b000));

  // R3: ordered predicates are false on unordered operands
  p_nan_false_r3: assert property (@(posedge clk) disable iff (srst)
    (vld_i && un && (op_i == CMP_LT || op_i == CMP_LE || op_i == CMP_EQ ||
                     op_i == CMP_GT || op_i == CMP_GE)) |-> !res_o[0]);

  // R7: undefined codes flag invalid with a zero result
  p_bad_op_r7: assert property (@(posedge clk) disable iff (srst)
    (vld_i && op_i > CMP_CCODE) |-> (inv_o && res_o == '0));

endmodule

// File: rtl/fp_cmp_pipe.sv
`timescale 1ns/1ps
// Top: classify -> [cut A] -> order -> [cut B] -> select -> [cut C]
module fp_cmp_pipe
  import fp_cmp_pkg::*;
#(
  parameter int FMT_W   = 32,
  parameter int FRAC_W  = 24,
  parameter int LATENCY = 3
) (
  input  logic             clk,
  input  logic             srst,
  input  logic             ce,
  input  logic             op_valid,
  input  logic [5:0]       op,
  input  logic [FMT_W-1:0] a,
  input  logic [FMT_W-1:0] b,
  output logic             res_valid,
  output logic [3:0]       result,
  output logic             invalid
);

  localparam int  MAG_W  = FMT_W - 1;
  localparam int  OPND_W = CLS_W + MAG_W;
  localparam int  A_W    = 2 * OPND_W + OP_W;
  localparam int  B_W    = CC_W + OP_W;
  localparam int  C_W    = CC_W + 1;
  localparam bit  CUT_A  = (LATENCY >= 3);
  localparam bit  CUT_B  = (LATENCY >= 2);
  localparam bit  CUT_C  = (LATENCY >= 1);

  // Classification of both operands
  fp_class_t        cls [2];
  logic [MAG_W-1:0] mag [2];
  logic [FMT_W-1:0] opnd [2];

  assign opnd[0] = a;
  assign opnd[1] = b;

  generate
    for (genvar i = 0; i < 2; i++) begin : g_cls
      fp_cmp_classify #(.FMT_W(FMT_W), .FRAC_W(FRAC_W)) u_cls (
        .word_i (opnd[i]),
        .cls_o  (cls[i]),
        .mag_o  (mag[i])
      );
    end
  endgenerate

  // Cut A
  logic             va;
  logic [A_W-1:0]   da;
  fp_class_t        ca_q, cb_q;
  logic [MAG_W-1:0] ma_q, mb_q;
  logic [OP_W-1:0]  op_a;

  fp_cmp_stage #(.W(A_W), .EN(CUT_A)) u_cut_a (
    .clk, .srst, .ce,
    .vld_i (op_valid),
    .d_i   ({cls[0], mag[0], cls[1], mag[1], op}),
    .vld_o (va),
    .d_o   (da)
  );

  assign {ca_q, ma_q, cb_q, mb_q, op_a} = da;

  // Relation
  logic [CC_W-1:0] rel;

  fp_cmp_order #(.MAG_W(MAG_W)) u_order (
    .ca_i  (ca_q),
    .cb_i  (cb_q),
    .ma_i  (ma_q),
    .mb_i  (mb_q),
    .rel_o (rel)
  );

  // Cut B
  logic            vb;
  logic [B_W-1:0]  db;
  logic [CC_W-1:0] rel_b;
  logic [OP_W-1:0] op_b;

  fp_cmp_stage #(.W(B_W), .EN(CUT_B)) u_cut_b (
    .clk, .srst, .ce,
    .vld_i (va),
    .d_i   ({rel, op_a}),
    .vld_o (vb),
    .d_o   (db)
  );

  assign {rel_b, op_b} = db;

  // Predicate selection
  logic [CC_W-1:0] sel_res;
  logic            sel_inv;

  fp_cmp_select u_select (
    .clk, .srst,
    .vld_i (vb),
    .op_i  (op_b),
    .rel_i (rel_b),
    .res_o (sel_res),
    .inv_o (sel_inv)
  );

  // Cut C (output register)
  logic [C_W-1:0] dc;

  fp_cmp_stage #(.W(C_W), .EN(CUT_C)) u_cut_c (
    .clk, .srst, .ce,
    .vld_i (vb),
    .d_i   ({sel_res, sel_inv}),
    .vld_o (res_valid),
    .d_o   (dc)
  );

  assign {result, invalid} = dc;

endmodule

// File: tb/fp_cmp_pipe_tb.sv
`timescale 1ns/1ps
module fp_cmp_pipe_tb;

  logic clk = 1'b0;
  always #2 clk = ~clk;   // 250 MHz

  logic        srst = 1'b1;
  logic        ce   = 1'b1;
  logic        op_valid = 1'b0;
  logic [5:0]  op = '0;
  logic [31:0] a = '0, b = '0;
  logic        res_valid, invalid;
  logic [3:0]  result;

  fp_cmp_pipe #(.FMT_W(32), .FRAC_W(24), .LATENCY(3)) u_dut (
    .clk, .srst, .ce, .op_valid, .op, .a, .b,
    .res_valid, .result, .invalid
  );

  // Combinational, half-width instance
  logic        v0 = 1'b0;
  logic [5:0]  op0 = '0;
  logic [15:0] a0 = '0, b0 = '0;
  logic        rv0, inv0;
  logic [3:0]  res0;

  fp_cmp_pipe #(.FMT_W(16), .FRAC_W(11), .LATENCY(0)) u_dut0 (
    .clk, .srst, .ce, .op_valid(v0), .op(op0), .a(a0), .b(b0),
    .res_valid(rv0), .result(res0), .invalid(inv0)
  );

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  task automatic chk(input string what, input int rq,
                     input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL R%0d %s: actual=%0h expected=%0h", rq, what, got, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  typedef struct packed {
    logic [31:0] a;
    logic [31:0] b;
    logic [5:0]  op;
    logic [3:0]  res;
    logic        inv;
    logic [3:0]  rq;
  } vec_t;

  localparam int NV = 27;
  localparam vec_t VEC [NV] = '{
    '{32'h3F800000, 32'h40000000, 6'd1, 4'h1, 1'b0, 4'd1},  // R1 1<2
    '{32'h40000000, 32'h3F800000, 6'd1, 4'h0, 1'b0, 4'd1},  // R1 2<1 false
    '{32'h3F800000, 32'h3F800000, 6'd3, 4'h1, 1'b0, 4'd1},  // R1 le
    '{32'h40000000, 32'h3F800000, 6'd4, 4'h1, 1'b0, 4'd1},  // R1 gt
    '{32'h3F800000, 32'h40000000, 6'd6, 4'h0, 1'b0, 4'd1},  // R1 ge false
    '{32'h3F800000, 32'h40000000, 6'd5, 4'h1, 1'b0, 4'd1},  // R1 ne
    '{32'h3F800000, 32'h3F800000, 6'd2, 4'h1, 1'b0, 4'd1},  // R1 eq
    '{32'h3F800000, 32'h40000000, 6'd0, 4'h0, 1'b0, 4'd1},  // R1 unordered false
    '{32'hBF800000, 32'hC0000000, 6'd7, 4'h4, 1'b0, 4'd5},  // R5 -1 > -2
    '{32'hC0000000, 32'hBF800000, 6'd7, 4'h2, 1'b0, 4'd5},  // R5 -2 < -1
    '{32'hBF800000, 32'h3F800000, 6'd1, 4'h1, 1'b0, 4'd5},  // R5 -1 < 1
    '{32'h7F800000, 32'h7F7FFFFF, 6'd4, 4'h1, 1'b0, 4'd5},  // R5 inf > max
    '{32'hFF800000, 32'hC0000000, 6'd7, 4'h2, 1'b0, 4'd5},  // R5 -inf < -2
    '{32'h80000000, 32'h3F800000, 6'd1, 4'h1, 1'b0, 4'd5},  // R5 -0 < 1
    '{32'h7FC00000, 32'h3F800000, 6'd7, 4'h8, 1'b0, 4'd2},  // R2 NaN -> UN bit
    '{32'h3F800000, 32'h3F800000, 6'd7, 4'h1, 1'b0, 4'd2},  // R2 EQ bit
    '{32'h7FC00000, 32'h3F800000, 6'd0, 4'h1, 1'b0, 4'd3},  // R3 unordered true
    '{32'h3F800000, 32'h7FC00000, 6'd1, 4'h0, 1'b1, 4'd6},  // R6 lt NaN
    '{32'h7FC00000, 32'h7FC00000, 6'd2, 4'h0, 1'b0, 4'd3},  // R3 eq NaN quiet
    '{32'h7FC00000, 32'h3F800000, 6'd5, 4'h1, 1'b0, 4'd3},  // R3 ne NaN true
    '{32'h7F800001, 32'h7F800000, 6'd6, 4'h0, 1'b1, 4'd6},  // R6 ge small NaN
    '{32'h00000000, 32'h80000000, 6'd2, 4'h1, 1'b0, 4'd4},  // R4 +0 == -0
    '{32'h00000001, 32'h80000001, 6'd7, 4'h1, 1'b0, 4'd4},  // R4 denorms equal
    '{32'h00000001, 32'h00000000, 6'd4, 4'h0, 1'b0, 4'd4},  // R4 denorm not > 0
    '{32'h00000000, 32'h80000001, 6'd6, 4'h1, 1'b0, 4'd4},  // R4 0 >= -denorm
    '{32'h3F800000, 32'h40000000, 6'd8, 4'h0, 1'b1, 4'd7},  // R7 code 8
    '{32'h3F800000, 32'h3F800000, 6'd63,4'h0, 1'b1, 4'd7}   // R7 code 63
  };

  // Apply one operation and sample after three edges (R8)
  task automatic run_op(input logic [31:0] ia, input logic [31:0] ib,
                        input logic [5:0] iop);
    @(negedge clk);
    a = ia; b = ib; op = iop; op_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    op_valid = 1'b0;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin : main
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("reset valid R10", 10, res_valid, 0);
    srst = 1'b0;

    // Table walk
    for (int i = 0; i < NV; i++) begin
      run_op(VEC[i].a, VEC[i].b, VEC[i].op);
      chk($sformatf("vec %0d valid", i), 8, res_valid, 1);
      chk($sformatf("vec %0d result", i), VEC[i].rq, result, VEC[i].res);
      chk($sformatf("vec %0d invalid", i), VEC[i].rq, invalid, VEC[i].inv);
    end

    // R8: not valid before the third edge
    @(negedge clk);
    a = 32'h3F800000; b = 32'h40000000; op = 6'd7; op_valid = 1'b1;
    @(posedge clk); @(negedge clk); op_valid = 1'b0;
    @(posedge clk); @(negedge clk);
    chk("R8 early valid", 8, res_valid, 0);
    @(posedge clk); @(negedge clk);
    chk("R8 on-time valid", 8, res_valid, 1);
    chk("R8 result", 8, result, 4'h2);
    @(posedge clk); @(negedge clk);
    chk("R8 single pulse", 8, res_valid, 0);

    // R9: freeze mid-pipe
    a = 32'h40000000; b = 32'h3F800000; op = 6'd7; op_valid = 1'b1;
    @(posedge clk); @(negedge clk);
    op_valid = 1'b0; ce = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R9 frozen no valid", 9, res_valid, 0);
    ce = 1'b1;
    @(posedge clk); @(negedge clk);
    chk("R9 still in flight", 9, res_valid, 0);
    @(posedge clk); @(negedge clk);
    chk("R9 resumed valid", 9, res_valid, 1);
    chk("R9 resumed result", 9, result, 4'h4);
    ce = 1'b0;
    @(posedge clk); @(negedge clk);
    chk("R9 valid held", 9, res_valid, 1);
    chk("R9 result held", 9, result, 4'h4);
    ce = 1'b1;
    @(posedge clk); @(negedge clk);
    chk("R9 valid drops", 9, res_valid, 0);

    // R10: clear drops in-flight work
    a = 32'h3F800000; b = 32'h3F800000; op = 6'd2; op_valid = 1'b1;
    @(posedge clk); @(negedge clk);
    op_valid = 1'b0; srst = 1'b1;
    @(posedge clk); @(negedge clk);
    srst = 1'b0;
    chk("R10 cleared", 10, res_valid, 0);
    @(posedge clk); @(negedge clk);
    chk("R10 no late valid 1", 10, res_valid, 0);
    @(posedge clk); @(negedge clk);
    chk("R10 no late valid 2", 10, res_valid, 0);

    // Combinational instance, 16-bit format (R8 latency 0)
    a0 = 16'h3C00; b0 = 16'h4000; op0 = 6'd7; v0 = 1'b1; #1;
    chk("L0 valid follows R8", 8, rv0, 1);
    chk("L0 1 vs 2 R2", 2, res0, 4'h2);
    a0 = 16'h7E00; b0 = 16'h7C00; op0 = 6'd4; #1;
    chk("L0 NaN gt R3", 3, res0, 4'h0);
    chk("L0 NaN gt invalid R6", 6, inv0, 1);
    a0 = 16'h8000; b0 = 16'h0001; op0 = 6'd2; #1;
    chk("L0 -0 eq denorm R4", 4, res0, 4'h1);
    a0 = 16'hFC00; b0 = 16'hBC00; op0 = 6'd1; #1;
    chk("L0 -inf lt -1 R5", 5, res0, 4'h1);
    v0 = 1'b0; #1;
    chk("L0 valid low R8", 8, rv0, 0);

    finish_run();
  end

endmodule